// File: doc/BRIEF.md
# Speculative Line Disambiguation Table

This block sits beside a directory controller in a multiprocessor that runs ordered threads speculatively in parallel. It keeps one entry per memory line that any speculative thread has touched. Each entry holds a line tag, a valid flag and two bit vectors indexed by thread number: one records which threads have loaded the line, the other which threads have stored to it. Threads occupy a fixed ring of slots; a head pointer names the oldest, non-speculative thread, and every other thread's position in program order is its distance from the head around the ring.

Each cycle the block accepts at most one request: a load, a store, a commit or a park. A store is checked against the line's load vector. Any later thread that already read the line has read a stale value, so it is reported for squashing, unless a thread between the two has already written the line. A park registers a reader that the controller chose to hold back on a line. Depending on the selected policy, that reader is released either when a predecessor whose write reaches it commits, or only when it becomes the oldest thread. A commit retires the oldest thread. Its bits are removed from every entry, entries left with no bits are freed, and the head moves on. All results are registered and appear on the cycle after the request.

Top module: `sldt_table`

## Requirements
- R1: After reset the table holds no valid entry, no reader is parked, `oldest_tid` is 0, and `squash_valid`, `squash_vec`, `alloc_stall` and `release_vec` are all zero.
- R2: A load or store whose tag misses takes the lowest free entry. A load or store whose tag hits reuses that entry and consumes no further storage.
- R3: A load or store that misses while all entries are valid is refused. `alloc_stall` is 1 in the next cycle and the table is left unchanged, so a refused load is never later flagged.
- R4: A store by thread t on a line raises `squash_valid` in the next cycle, with `squash_vec` bit u set, for every thread u that is later than t in order and has its load bit set on that line. Outputs are zero in cycles that follow no such store.
- R5: A later loader u is not flagged when some thread v strictly between t and u in order has its store bit set on that line.
- R6: Order is the distance from `oldest_tid` modulo the thread count. `squash_tid` gives the flagged thread that is earliest in that order, including when the ring wraps.
- R7: The storing thread, the oldest thread and every loader earlier than the store are never flagged.
- R8: A commit (`req_op` = 2) whose `req_tid` is not `oldest_tid` is ignored. `oldest_tid` holds, no bits are cleared and nothing is released.
- R9: A commit by the oldest thread clears that thread's load and store bits in every entry and frees every entry left with no bits. `oldest_tid` advances by one, modulo the thread count.
- R10: With `wait_mode` = 0, a commit by the oldest thread h releases a parked reader u on a line where h's store bit is set, when no thread between h and u holds a store bit on that line. The release shows as `release_vec` bit u in the next cycle.
- R11: With `wait_mode` = 0, a parked reader is kept stalled at a commit when a thread between the committer and the reader has stored to the line.
- R12: With `wait_mode` = 1, a parked reader is released only in the cycle after it becomes the oldest thread.
- R13: In both modes, a thread that becomes oldest through a commit while parked is released. A park (`req_op` = 3) issued by the oldest thread itself is released in the next cycle. Op codes: 0 load, 1 store, 2 commit, 3 park.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 commit, 3 park |
| req_tag | input | TAG_W | Line tag of the request |
| req_tid | input | TID_W | Thread slot issuing the request |
| wait_mode | input | 1 | 0 release on predecessor commit, 1 release only on becoming oldest |
| oldest_tid | output | TID_W | Slot of the current non-speculative thread |
| squash_valid | output | 1 | The previous request flagged at least one thread |
| squash_tid | output | TID_W | Earliest flagged thread in program order |
| squash_vec | output | NUM_THREADS | All flagged threads |
| alloc_stall | output | 1 | The previous request needed an entry and none was free |
| release_vec | output | NUM_THREADS | Parked threads released by the previous request |

## Verification
The bound checker watches, on every cycle, the rules that can be read from the ports alone. A squash report must carry its earliest thread inside the vector, and it must follow a store. It never names the oldest thread or the thread that stored. The head moves exactly when the oldest thread commits, and by one slot. A stall follows only a load or store and never coincides with a squash. In the wait policy only the oldest thread is released. The directed scenarios are needed for the things that depend on history held in the table. These are which loaders a store reaches once intervening writers are taken into account, the earliest-thread choice after the ring wraps, the freeing of entries at commit, the refusal of an allocation with the table left intact, and whether a parked reader is released by a predecessor's commit.

// File: rtl/sldt_pkg.sv
package sldt_pkg;
   typedef enum logic [1:0] {
      OP_LOAD   = 2'd0,
      OP_STORE  = 2'd1,
      OP_COMMIT = 2'd2,
      OP_PARK   = 2'd3
   } sldt_op_e;
endpackage

// File: rtl/sldt_lookup.sv
module sldt_lookup #(
   parameter int NUM_ENTRIES = 16,
   parameter int TAG_W       = 16,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic [NUM_ENTRIES-1:0]            ent_vld,
   input  logic [NUM_ENTRIES-1:0][TAG_W-1:0] ent_tag,
   input  logic [TAG_W-1:0]                  key,
   output logic                              hit,
   output logic [IDX_W-1:0]                  hit_idx,
   output logic                              free_any,
   output logic [IDX_W-1:0]                  free_idx
);
   logic [NUM_ENTRIES-1:0] match;

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
      assign match[g] = ent_vld[g] && (ent_tag[g] == key);
   end

   always_comb begin
      hit      = 1'b0;
      hit_idx  = '0;
      free_any = 1'b0;
      free_idx = '0;
      for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
         if (match[e]) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(e);
         end
         if (!ent_vld[e]) begin
            free_any = 1'b1;
            free_idx = IDX_W'(e);
         end
      end
   end
endmodule

// File: rtl/sldt_order_check.sv
module sldt_order_check #(
   parameter int NUM_THREADS = 8,
   localparam int TID_W      = $clog2(NUM_THREADS)
) (
   input  logic [NUM_THREADS-1:0] ld_vec,
   input  logic [NUM_THREADS-1:0] st_vec,
   input  logic [TID_W-1:0]       head,
   input  logic [TID_W-1:0]       writer,
   output logic [NUM_THREADS-1:0] flag_vec,
   output logic                   flag_any,
   output logic [TID_W-1:0]       first_tid
);
   logic [TID_W-1:0] w_rank;
   logic             blocked;
   logic             found;
   logic [TID_W-1:0] slot;

   assign w_rank = writer - head;

   always_comb begin
      flag_vec  = '0;
      flag_any  = 1'b0;
      first_tid = '0;
      blocked   = 1'b0;
      found     = 1'b0;
      slot      = '0;
      for (int r = 0; r < NUM_THREADS; r++) begin
         slot = head + TID_W'(r);
         if (TID_W'(r) > w_rank) begin
            if (ld_vec[slot] && !blocked) begin
               flag_vec[slot] = 1'b1;
               if (!found) begin
                  found     = 1'b1;
                  first_tid = slot;
               end
            end
            if (st_vec[slot]) blocked = 1'b1;
         end
      end
      flag_any = found;
   end
endmodule

// File: rtl/sldt_release.sv
module sldt_release #(
   parameter int NUM_THREADS = 8,
   parameter int NUM_ENTRIES = 16,
   parameter int TAG_W       = 16,
   localparam int TID_W      = $clog2(NUM_THREADS)
) (
   input  logic [TID_W-1:0]                        head,
   input  logic                                    wait_mode,
   input  logic [NUM_THREADS-1:0]                  wait_vld,
   input  logic [NUM_THREADS-1:0][TAG_W-1:0]       wait_tag,
   input  logic [NUM_ENTRIES-1:0]                  ent_vld,
   input  logic [NUM_ENTRIES-1:0][TAG_W-1:0]       ent_tag,
   input  logic [NUM_ENTRIES-1:0][NUM_THREADS-1:0] ent_st,
   output logic [NUM_THREADS-1:0]                  rel_vec
);
   logic [TID_W-1:0] rk;
   logic [TID_W-1:0] slot;
   logic             clear;

   always_comb begin
      rel_vec = '0;
      rk      = '0;
      slot    = '0;
      clear   = 1'b0;
      for (int u = 0; u < NUM_THREADS; u++) begin
         rk = TID_W'(u) - head;
         if (wait_vld[u]) begin
            if (rk == TID_W'(1)) begin
               rel_vec[u] = 1'b1;
            end else if (!wait_mode && rk != '0) begin
               for (int e = 0; e < NUM_ENTRIES; e++) begin
                  if (ent_vld[e] && ent_tag[e] == wait_tag[u] && ent_st[e][head]) begin
                     clear = 1'b1;
                     for (int r = 1; r < NUM_THREADS; r++) begin
                        slot = head + TID_W'(r);
                        if (TID_W'(r) < rk && ent_st[e][slot]) clear = 1'b0;
                     end
                     if (clear) rel_vec[u] = 1'b1;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/sldt_table.sv
module sldt_table
   import sldt_pkg::*;
#(
   parameter int NUM_THREADS = 8,
   parameter int NUM_ENTRIES = 16,
   parameter int TAG_W       = 16,
   localparam int TID_W      = $clog2(NUM_THREADS),
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [1:0]             req_op,
   input  logic [TAG_W-1:0]       req_tag,
   input  logic [TID_W-1:0]       req_tid,
   input  logic                   wait_mode,
   output logic [TID_W-1:0]       oldest_tid,
   output logic                   squash_valid,
   output logic [TID_W-1:0]       squash_tid,
   output logic [NUM_THREADS-1:0] squash_vec,
   output logic                   alloc_stall,
   output logic [NUM_THREADS-1:0] release_vec
);
   if (NUM_THREADS < 2 || (NUM_THREADS & (NUM_THREADS - 1)) != 0) begin : g_bad_threads
      $error("NUM_THREADS must be a power of two of at least 2");
   end
   if (NUM_ENTRIES < 2) begin : g_bad_entries
      $error("NUM_ENTRIES must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("TAG_W must be positive");
   end

   logic [NUM_ENTRIES-1:0]                  ent_vld;
   logic [NUM_ENTRIES-1:0][TAG_W-1:0]       ent_tag;
   logic [NUM_ENTRIES-1:0][NUM_THREADS-1:0] ent_ld;
   logic [NUM_ENTRIES-1:0][NUM_THREADS-1:0] ent_st;
   logic [NUM_THREADS-1:0]                  wait_vld;
   logic [NUM_THREADS-1:0][TAG_W-1:0]       wait_tag;
   logic [TID_W-1:0]                        head;

   sldt_op_e op;
   logic is_ld, is_st, is_cm, is_pk, is_access;
   logic hit, free_any, do_set, stall;
   logic [IDX_W-1:0] hit_idx, free_idx, tgt;
   logic [NUM_THREADS-1:0] tid_oh, head_oh;
   logic [NUM_THREADS-1:0] flag_vec, rel_cm, rel_next;
   logic flag_any;
   logic [TID_W-1:0] first_tid;

   assign op        = sldt_op_e'(req_op);
   assign is_ld     = req_valid && op == OP_LOAD;
   assign is_st     = req_valid && op == OP_STORE;
   assign is_cm     = req_valid && op == OP_COMMIT && req_tid == head;
   assign is_pk     = req_valid && op == OP_PARK;
   assign is_access = is_ld || is_st;
   assign tid_oh    = NUM_THREADS'(1) << req_tid;
   assign head_oh   = NUM_THREADS'(1) << head;

   sldt_lookup #(.NUM_ENTRIES(NUM_ENTRIES), .TAG_W(TAG_W)) u_lookup (
      .ent_vld  (ent_vld),
      .ent_tag  (ent_tag),
      .key      (req_tag),
      .hit      (hit),
      .hit_idx  (hit_idx),
      .free_any (free_any),
      .free_idx (free_idx)
   );

   assign stall  = is_access && !hit && !free_any;
   assign do_set = is_access && (hit || free_any);
   assign tgt    = hit ? hit_idx : free_idx;

   sldt_order_check #(.NUM_THREADS(NUM_THREADS)) u_order (
      .ld_vec    (ent_ld[hit_idx]),
      .st_vec    (ent_st[hit_idx]),
      .head      (head),
      .writer    (req_tid),
      .flag_vec  (flag_vec),
      .flag_any  (flag_any),
      .first_tid (first_tid)
   );

   sldt_release #(
      .NUM_THREADS (NUM_THREADS),
      .NUM_ENTRIES (NUM_ENTRIES),
      .TAG_W       (TAG_W)
   ) u_release (
      .head      (head),
      .wait_mode (wait_mode),
      .wait_vld  (wait_vld),
      .wait_tag  (wait_tag),
      .ent_vld   (ent_vld),
      .ent_tag   (ent_tag),
      .ent_st    (ent_st),
      .rel_vec   (rel_cm)
   );

   always_comb begin
      rel_next = '0;
      if (is_cm) rel_next = rel_cm;
      else if (is_pk && req_tid == head) rel_next = tid_oh;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_vld      <= '0;
         ent_tag      <= '0;
         ent_ld       <= '0;
         ent_st       <= '0;
         wait_vld     <= '0;
         wait_tag     <= '0;
         head         <= '0;
         squash_valid <= 1'b0;
         squash_tid   <= '0;
         squash_vec   <= '0;
         alloc_stall  <= 1'b0;
         release_vec  <= '0;
      end else begin
         squash_valid <= is_st && hit && flag_any;
         squash_vec   <= (is_st && hit) ? flag_vec : '0;
         squash_tid   <= (is_st && hit && flag_any) ? first_tid : '0;
         alloc_stall  <= stall;
         release_vec  <= rel_next;

         if (do_set) begin
            ent_vld[tgt] <= 1'b1;
            ent_tag[tgt] <= req_tag;
            ent_ld[tgt]  <= (hit ? ent_ld[tgt] : '0) | (is_ld ? tid_oh : '0);
            ent_st[tgt]  <= (hit ? ent_st[tgt] : '0) | (is_st ? tid_oh : '0);
         end

         if (is_cm) begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
               ent_ld[e][head] <= 1'b0;
               ent_st[e][head] <= 1'b0;
               if ((ent_ld[e] & ~head_oh) == '0 && (ent_st[e] & ~head_oh) == '0)
                  ent_vld[e] <= 1'b0;
            end
            head     <= head + TID_W'(1);
            wait_vld <= wait_vld & ~rel_cm;
         end

         if (is_pk && req_tid != head) begin
            wait_vld[req_tid] <= 1'b1;
            wait_tag[req_tid] <= req_tag;
         end
      end
   end

   assign oldest_tid = head;
endmodule

// File: rtl/sldt_checker.sv
module sldt_checker
   import sldt_pkg::*;
#(
   parameter int NUM_THREADS = 8,
   localparam int TID_W      = $clog2(NUM_THREADS)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic [1:0]             req_op,
   input logic [TID_W-1:0]       req_tid,
   input logic                   wait_mode,
   input logic [TID_W-1:0]       oldest_tid,
   input logic                   squash_valid,
   input logic [TID_W-1:0]       squash_tid,
   input logic [NUM_THREADS-1:0] squash_vec,
   input logic                   alloc_stall,
   input logic [NUM_THREADS-1:0] release_vec
);
   logic is_store, is_commit_old, is_access, is_cm_or_pk;
   assign is_store      = req_valid && req_op == OP_STORE;
   assign is_commit_old = req_valid && req_op == OP_COMMIT && req_tid == oldest_tid;
   assign is_access     = req_valid && (req_op == OP_LOAD || req_op == OP_STORE);
   assign is_cm_or_pk   = req_valid && (req_op == OP_COMMIT || req_op == OP_PARK);

   p_first_in_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid |-> squash_vec[squash_tid]);

   p_squash_after_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (squash_vec != '0) |-> $past(is_store));

   p_oldest_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid |-> !squash_vec[oldest_tid]);

   p_writer_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      is_store |=> !squash_vec[$past(req_tid)]);

   p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !is_commit_old |=> $stable(oldest_tid));

   p_head_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      is_commit_old |=> oldest_tid == TID_W'($past(oldest_tid) + TID_W'(1)));

   p_stall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_stall |-> $past(is_access));

   p_stall_no_squash_r3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_stall |-> !squash_valid);

   p_wait_oldest_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wait_mode |=> (release_vec & ~(NUM_THREADS'(1) << oldest_tid)) == '0);

   p_release_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (release_vec != '0) |-> $past(is_cm_or_pk));
endmodule

bind sldt_table sldt_checker #(.NUM_THREADS(NUM_THREADS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_op       (req_op),
   .req_tid      (req_tid),
   .wait_mode    (wait_mode),
   .oldest_tid   (oldest_tid),
   .squash_valid (squash_valid),
   .squash_tid   (squash_tid),
   .squash_vec   (squash_vec),
   .alloc_stall  (alloc_stall),
   .release_vec  (release_vec)
);

// File: tb/sim_sldt_table.sv
`timescale 1ns/1ps
module sim_sldt_table;
   localparam int NT = 8;
   localparam int NE = 16;
   localparam int TW = 16;
   localparam int IW = $clog2(NT);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [TW-1:0] req_tag = '0;
   logic [IW-1:0] req_tid = '0;
   logic          wait_mode = 1'b0;
   logic [IW-1:0] oldest_tid;
   logic          squash_valid;
   logic [IW-1:0] squash_tid;
   logic [NT-1:0] squash_vec;
   logic          alloc_stall;
   logic [NT-1:0] release_vec;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   sldt_table #(.NUM_THREADS(NT), .NUM_ENTRIES(NE), .TAG_W(TW)) u0 (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_req(input logic [1:0] op, input logic [TW-1:0] tag, input int tid);
      @(negedge clk);
      req_valid = 1'b1;
      req_op    = op;
      req_tag   = tag;
      req_tid   = IW'(tid);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 oldest", 32'(oldest_tid), 0);
      chk("R1 squash_valid", 32'(squash_valid), 0);
      chk("R1 squash_vec", 32'(squash_vec), 0);
      chk("R1 alloc_stall", 32'(alloc_stall), 0);
      chk("R1 release_vec", 32'(release_vec), 0);
   endtask

   task automatic t_squash_basic();
      do_reset();
      do_req(2'd0, 16'h0010, 0);
      do_req(2'd0, 16'h0010, 3);
      do_req(2'd0, 16'h0010, 5);
      chk("R4 no squash on load", 32'(squash_valid), 0);
      do_req(2'd1, 16'h0010, 1);
      chk("R4 squash_valid", 32'(squash_valid), 1);
      chk("R4 squash_vec", 32'(squash_vec), 32'h28);
      chk("R6 earliest", 32'(squash_tid), 3);
      chk("R7 earlier and writer clear", 32'(squash_vec & 8'h03), 0);
   endtask

   task automatic t_intervening();
      do_reset();
      do_req(2'd0, 16'h0020, 6);
      do_req(2'd1, 16'h0020, 4);
      do_req(2'd0, 16'h0020, 2);
      do_req(2'd1, 16'h0020, 1);
      chk("R5 blocked vec", 32'(squash_vec), 32'h04);
      chk("R6 earliest blocked case", 32'(squash_tid), 2);
      do_req(2'd1, 16'h0020, 3);
      chk("R5 fully blocked", 32'(squash_valid), 0);
   endtask

   task automatic t_wrap();
      do_reset();
      for (int i = 0; i < 6; i++) do_req(2'd2, 16'h0000, i);
      chk("R9 head after six", 32'(oldest_tid), 6);
      do_req(2'd0, 16'h0030, 1);
      do_req(2'd0, 16'h0030, 7);
      do_req(2'd1, 16'h0030, 6);
      chk("R6 wrap vec", 32'(squash_vec), 32'h82);
      chk("R6 wrap earliest", 32'(squash_tid), 7);
      do_req(2'd1, 16'h0030, 0);
      chk("R7 wrap earlier loader", 32'(squash_vec), 32'h02);
      chk("R6 wrap earliest 2", 32'(squash_tid), 1);
   endtask

   task automatic t_commit();
      do_reset();
      do_req(2'd0, 16'h0040, 1);
      do_req(2'd0, 16'h0040, 2);
      do_req(2'd2, 16'h0000, 5);
      chk("R8 head holds", 32'(oldest_tid), 0);
      chk("R8 no release", 32'(release_vec), 0);
      do_req(2'd2, 16'h0000, 0);
      do_req(2'd2, 16'h0000, 1);
      chk("R9 head advanced", 32'(oldest_tid), 2);
      do_req(2'd1, 16'h0040, 2);
      chk("R9 committed bits cleared", 32'(squash_vec), 0);
   endtask

   task automatic t_full();
      int stalls;
      do_reset();
      stalls = 0;
      for (int i = 0; i < NE; i++) begin
         do_req(2'd0, 16'h0100 + 16'(i), 2);
         if (alloc_stall) stalls++;
      end
      chk("R2 fill without stall", 32'(stalls), 0);
      do_req(2'd0, 16'h0100, 3);
      chk("R2 hit when full", 32'(alloc_stall), 0);
      do_req(2'd0, 16'h0200, 6);
      chk("R3 load refused", 32'(alloc_stall), 1);
      do_req(2'd1, 16'h0200, 4);
      chk("R3 store refused", 32'(alloc_stall), 1);
      do_req(2'd1, 16'h0100, 1);
      chk("R4 full table squash", 32'(squash_vec), 32'h0C);
      do_req(2'd2, 16'h0000, 0);
      do_req(2'd2, 16'h0000, 1);
      do_req(2'd2, 16'h0000, 2);
      do_req(2'd1, 16'h0200, 4);
      chk("R9 entry freed", 32'(alloc_stall), 0);
      chk("R3 refused load not kept", 32'(squash_valid), 0);
   endtask

   task automatic t_release();
      do_reset();
      wait_mode = 1'b0;
      do_req(2'd1, 16'h0050, 0);
      do_req(2'd3, 16'h0050, 3);
      do_req(2'd3, 16'h0050, 1);
      chk("R10 park quiet", 32'(release_vec), 0);
      do_req(2'd2, 16'h0000, 0);
      chk("R10 R13 release on commit", 32'(release_vec), 32'h0A);
      do_reset();
      do_req(2'd1, 16'h0060, 0);
      do_req(2'd1, 16'h0060, 2);
      do_req(2'd3, 16'h0060, 4);
      do_req(2'd2, 16'h0000, 0);
      chk("R11 intervening writer", 32'(release_vec), 0);
      do_req(2'd2, 16'h0000, 1);
      chk("R11 non writer commit", 32'(release_vec), 0);
      do_req(2'd2, 16'h0000, 2);
      chk("R10 nearest writer commit", 32'(release_vec), 32'h10);
      do_req(2'd3, 16'h0060, 3);
      chk("R13 oldest parks", 32'(release_vec), 32'h08);
   endtask

   task automatic t_wait();
      do_reset();
      wait_mode = 1'b1;
      do_req(2'd1, 16'h0070, 0);
      do_req(2'd3, 16'h0070, 3);
      do_req(2'd2, 16'h0000, 0);
      chk("R12 writer commit no release", 32'(release_vec), 0);
      do_req(2'd2, 16'h0000, 1);
      chk("R12 still parked", 32'(release_vec), 0);
      do_req(2'd2, 16'h0000, 2);
      chk("R12 R13 becomes oldest", 32'(release_vec), 32'h08);
      wait_mode = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=<20000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_squash_basic();
      t_intervening();
      t_wrap();
      t_commit();
      t_full();
      t_release();
      t_wait();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule